// File: doc/BRIEF.md
# Accumulator Logic and Compare Unit

This block is the bitwise and compare slice of an 8-bit processor datapath. It takes the current accumulator, a second operand and a three-bit operation code. From these it works out the next accumulator value, a write strobe for the accumulator, and the next zero, subtract, half-carry and carry flags. The operand may come from a register, a memory byte or an immediate; the block does not care which. The unit is purely combinational. The accumulator and the flag register that capture its outputs live in the surrounding datapath.

Four operations change the accumulator: the three bitwise ones (AND, OR, XOR) and the one's complement. Compare works differently. It produces the flags that a subtraction of the operand from the accumulator would give, then drops the difference and raises no write strobe. The complement leaves the zero and carry flags as they were. For that reason, the current packed flag byte is also an input. The flags go out in two forms: as four single bits, and packed into one byte in a fixed layout that the flag register and the stack-push path both rely on.

Top module: `acc_alu`

## Requirements
- R1: Operation code 3'b000 (AND) drives the bitwise AND of accumulator and operand onto `acc_o` with `acc_we_o`=1. The flags become Z = result is zero, N=0, H=1, C=0.
- R2: Operation codes 3'b001 (OR) and 3'b010 (XOR) drive the bitwise OR or XOR onto `acc_o` with `acc_we_o`=1. The flags become Z = result is zero, N=0, H=0, C=0.
- R3: Operation code 3'b011 (compare) holds `acc_we_o`=0 and passes the accumulator through unchanged on `acc_o`. It sets N=1, and sets Z exactly when operand and accumulator are equal.
- R4: For compare, C is 1 exactly when the operand, taken as unsigned, is larger than the accumulator; this is the borrow of accumulator minus operand.
- R5: For compare, H is 1 exactly when the low four bits of the operand, taken as unsigned, exceed the low four bits of the accumulator.
- R6: Operation code 3'b100 (complement) drives the inversion of all accumulator bits with `acc_we_o`=1. It sets N=1 and H=1, and copies Z from bit 7 and C from bit 4 of `flag_byte_i`.
- R7: `flag_byte_o` carries Z in bit 7, N in bit 6, H in bit 5 and C in bit 4. Bits 3 to 0 are always 0. `zf_o`, `nf_o`, `hf_o` and `cf_o` equal bits 7, 6, 5 and 4 of `flag_byte_o`.
- R8: Operation codes 3'b101, 3'b110 and 3'b111 have no effect. `acc_we_o`=0, `acc_o` equals `acc_i`, bits 7 to 4 of `flag_byte_o` equal bits 7 to 4 of `flag_byte_i`, and bits 3 to 0 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_i | input | 8 | Current accumulator value |
| opnd_i | input | 8 | Second operand |
| op_i | input | 3 | Operation code |
| flag_byte_i | input | 8 | Current packed flag byte |
| acc_o | output | 8 | Next accumulator value |
| acc_we_o | output | 1 | Accumulator write strobe |
| flag_byte_o | output | 8 | Next packed flag byte |
| zf_o | output | 1 | Next zero flag |
| nf_o | output | 1 | Next subtract flag |
| hf_o | output | 1 | Next half-carry flag |
| cf_o | output | 1 | Next carry flag |

## Verification
The bench aims at the compare cases where the nibble borrow and the full borrow separate. An operand larger only in the low nibble must give H without C, and an operand larger only in the high nibble must give C without H. A design that takes H from bit 3 of the difference, or that swaps the operands, turns these flag pairs around. Equal operands must give Z with both borrows clear, and a compare must never raise the write strobe. Complement is run with opposite incoming flag bytes to show that Z and C pass through rather than being recomputed. The reserved codes are checked for a silent accumulator and an untouched flag byte. A pseudo-random sweep also covers zero results of AND and XOR, where a swapped Z polarity or a misplaced packed bit shows up at once.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

   // operation codes seen on op_i
   typedef enum logic [2:0] {
      OP_AND = 3'd0,
      OP_OR  = 3'd1,
      OP_XOR = 3'd2,
      OP_CMP = 3'd3,
      OP_CPL = 3'd4
   } alu_op_e;

   // bit positions of the packed flag byte
   localparam int FLAG_BYTE_W = 8;
   localparam int ZF_POS      = 7;
   localparam int NF_POS      = 6;
   localparam int HF_POS      = 5;
   localparam int CF_POS      = 4;

   typedef struct packed {
      logic z;
      logic n;
      logic h;
      logic c;
   } alu_flags_t;

endpackage

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
   import acc_alu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic [2:0]        op_i,
   output logic [DATA_W-1:0] res_o,
   output logic              zero_o
);

   initial begin
      if (DATA_W < 2)
         $error("acc_alu_logic: DATA_W must be at least 2");
   end

   logic [DATA_W-1:0] and_v;
   logic [DATA_W-1:0] or_v;
   logic [DATA_W-1:0] xor_v;
   logic [DATA_W-1:0] not_v;

   // one slice per bit
   for (genvar gi = 0; gi < DATA_W; gi++) begin : g_bit
      assign and_v[gi] = a_i[gi] & b_i[gi];
      assign or_v[gi]  = a_i[gi] | b_i[gi];
      assign xor_v[gi] = a_i[gi] ^ b_i[gi];
      assign not_v[gi] = ~a_i[gi];
   end

   always_comb begin
      case (op_i)
         OP_AND:  res_o = and_v;
         OP_OR:   res_o = or_v;
         OP_XOR:  res_o = xor_v;
         OP_CPL:  res_o = not_v;
         default: res_o = a_i;
      endcase
   end

   assign zero_o = ~|res_o;

   always_comb begin
      // R1
      and_subset_chk: assert (op_i != OP_AND || (res_o & ~b_i) == '0);
      // R2
      or_superset_chk: assert (op_i != OP_OR || (a_i & ~res_o) == '0);
   end

endmodule

// File: rtl/acc_alu_cmp.sv
module acc_alu_cmp #(
   parameter int DATA_W   = 8,
   parameter int HALF_W   = 4,
   parameter int CMP_IMPL = 0
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   output logic              eq_o,
   output logic              borrow_o,
   output logic              half_borrow_o
);

   initial begin
      if (HALF_W < 1 || HALF_W >= DATA_W)
         $error("acc_alu_cmp: HALF_W must lie in 1..DATA_W-1");
      if (CMP_IMPL != 0 && CMP_IMPL != 1)
         $error("acc_alu_cmp: CMP_IMPL must be 0 or 1");
   end

   if (CMP_IMPL == 0) begin : g_sub
      // subtractor: borrows are the extra top bits
      logic [DATA_W:0] diff;
      logic [HALF_W:0] ldiff;
      assign diff          = {1'b0, a_i} - {1'b0, b_i};
      assign ldiff         = {1'b0, a_i[HALF_W-1:0]} - {1'b0, b_i[HALF_W-1:0]};
      assign eq_o          = ~|diff[DATA_W-1:0];
      assign borrow_o      = diff[DATA_W];
      assign half_borrow_o = ldiff[HALF_W];
   end else begin : g_mag
      // magnitude comparators, no subtractor
      assign eq_o          = (a_i == b_i);
      assign borrow_o      = (b_i > a_i);
      assign half_borrow_o = (b_i[HALF_W-1:0] > a_i[HALF_W-1:0]);
   end

   always_comb begin
      // R4
      eq_no_borrow_chk: assert (!(eq_o && borrow_o));
      // R5
      eq_no_half_chk: assert (!(eq_o && half_borrow_o));
   end

endmodule

// File: rtl/acc_alu_flags.sv
module acc_alu_flags
   import acc_alu_pkg::*;
(
   input  alu_flags_t             flags_i,
   output logic [FLAG_BYTE_W-1:0] byte_o
);

   for (genvar gi = 0; gi < FLAG_BYTE_W; gi++) begin : g_pack
      if (gi == ZF_POS) begin : g_z
         assign byte_o[gi] = flags_i.z;
      end else if (gi == NF_POS) begin : g_n
         assign byte_o[gi] = flags_i.n;
      end else if (gi == HF_POS) begin : g_h
         assign byte_o[gi] = flags_i.h;
      end else if (gi == CF_POS) begin : g_c
         assign byte_o[gi] = flags_i.c;
      end else begin : g_zero
         assign byte_o[gi] = 1'b0;
      end
   end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_alu_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int HALF_W   = 4,
   parameter int CMP_IMPL = 0
) (
   input  logic [DATA_W-1:0]      acc_i,
   input  logic [DATA_W-1:0]      opnd_i,
   input  logic [2:0]             op_i,
   input  logic [FLAG_BYTE_W-1:0] flag_byte_i,
   output logic [DATA_W-1:0]      acc_o,
   output logic                   acc_we_o,
   output logic [FLAG_BYTE_W-1:0] flag_byte_o,
   output logic                   zf_o,
   output logic                   nf_o,
   output logic                   hf_o,
   output logic                   cf_o
);

   initial begin
      if (DATA_W != 8)
         $error("acc_alu: flag packing expects an 8-bit datapath");
   end

   logic [DATA_W-1:0] logic_res;
   logic              logic_zero;
   logic              cmp_eq;
   logic              cmp_borrow;
   logic              cmp_half;
   alu_flags_t        nxt_flags;

   acc_alu_logic #(.DATA_W(DATA_W)) i_logic (
      .a_i    (acc_i),
      .b_i    (opnd_i),
      .op_i   (op_i),
      .res_o  (logic_res),
      .zero_o (logic_zero)
   );

   acc_alu_cmp #(.DATA_W(DATA_W), .HALF_W(HALF_W), .CMP_IMPL(CMP_IMPL)) i_cmp (
      .a_i           (acc_i),
      .b_i           (opnd_i),
      .eq_o          (cmp_eq),
      .borrow_o      (cmp_borrow),
      .half_borrow_o (cmp_half)
   );

   always_comb begin
      acc_o     = acc_i;
      acc_we_o  = 1'b0;
      nxt_flags = '{z: flag_byte_i[ZF_POS], n: flag_byte_i[NF_POS],
                    h: flag_byte_i[HF_POS], c: flag_byte_i[CF_POS]};
      case (op_i)
         OP_AND: begin
            acc_o     = logic_res;
            acc_we_o  = 1'b1;
            nxt_flags = '{z: logic_zero, n: 1'b0, h: 1'b1, c: 1'b0};
         end
         OP_OR, OP_XOR: begin
            acc_o     = logic_res;
            acc_we_o  = 1'b1;
            nxt_flags = '{z: logic_zero, n: 1'b0, h: 1'b0, c: 1'b0};
         end
         OP_CMP: begin
            nxt_flags = '{z: cmp_eq, n: 1'b1, h: cmp_half, c: cmp_borrow};
         end
         OP_CPL: begin
            acc_o       = logic_res;
            acc_we_o    = 1'b1;
            nxt_flags.n = 1'b1;
            nxt_flags.h = 1'b1;
         end
         default: ;
      endcase
   end

   acc_alu_flags i_flags (
      .flags_i (nxt_flags),
      .byte_o  (flag_byte_o)
   );

   assign zf_o = nxt_flags.z;
   assign nf_o = nxt_flags.n;
   assign hf_o = nxt_flags.h;
   assign cf_o = nxt_flags.c;

   always_comb begin
      // R3
      no_write_keeps_acc_chk: assert (acc_we_o || acc_o == acc_i);
      // R3
      cmp_never_writes_chk: assert (op_i != OP_CMP || (!acc_we_o && nf_o));
      // R7
      low_nibble_zero_chk: assert (flag_byte_o[3:0] == 4'h0);
      // R7
      packed_matches_bits_chk: assert (flag_byte_o[7:4] == {zf_o, nf_o, hf_o, cf_o});
   end

endmodule

// File: tb/test_acc_alu.sv
module test_acc_alu;

   typedef struct {
      logic [7:0] acc;
      logic       we;
      logic [7:0] fb;
      string      req;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] acc_i = 8'h00;
   logic [7:0] opnd_i = 8'h00;
   logic [2:0] op_i = 3'd7;
   logic [7:0] flag_byte_i = 8'h00;
   logic [7:0] acc_o;
   logic       acc_we_o;
   logic [7:0] flag_byte_o;
   logic       zf_o, nf_o, hf_o, cf_o;

   int total = 0;
   int bad = 0;
   bit drv_done = 1'b0;
   exp_t sb[$];

   always #2 clk = ~clk;

   acc_alu i_acc_alu (
      .acc_i       (acc_i),
      .opnd_i      (opnd_i),
      .op_i        (op_i),
      .flag_byte_i (flag_byte_i),
      .acc_o       (acc_o),
      .acc_we_o    (acc_we_o),
      .flag_byte_o (flag_byte_o),
      .zf_o        (zf_o),
      .nf_o        (nf_o),
      .hf_o        (hf_o),
      .cf_o        (cf_o)
   );

   function automatic exp_t model(input logic [7:0] a, input logic [7:0] b,
                                  input logic [2:0] op, input logic [7:0] fi);
      exp_t e;
      logic [7:0] r;
      e.acc = a; e.we = 1'b0; e.fb = {fi[7:4], 4'h0};
      case (op)
         3'd0: begin r = a & b; e.acc = r; e.we = 1'b1;
                     e.fb = {(r == 8'h00), 3'b010, 4'h0}; e.req = "R1"; end
         3'd1: begin r = a | b; e.acc = r; e.we = 1'b1;
                     e.fb = {(r == 8'h00), 3'b000, 4'h0}; e.req = "R2"; end
         3'd2: begin r = a ^ b; e.acc = r; e.we = 1'b1;
                     e.fb = {(r == 8'h00), 3'b000, 4'h0}; e.req = "R2"; end
         3'd3: begin e.fb = {(a == b), 1'b1, (b[3:0] > a[3:0]), (b > a), 4'h0};
                     e.req = "R3/R4/R5"; end
         3'd4: begin e.acc = ~a; e.we = 1'b1;
                     e.fb = {fi[7], 1'b1, 1'b1, fi[4], 4'h0}; e.req = "R6"; end
         default: e.req = "R8";
      endcase
      return e;
   endfunction

   task automatic drive(input logic [7:0] a, input logic [7:0] b,
                        input logic [2:0] op, input logic [7:0] fi);
      @(posedge clk);
      #1;
      acc_i = a; opnd_i = b; op_i = op; flag_byte_i = fi;
      sb.push_back(model(a, b, op, fi));
   endtask

   // monitor: compare half a period after each drive
   initial begin
      exp_t e;
      forever begin
         @(negedge clk);
         if (sb.size() != 0) begin
            e = sb.pop_front();
            total++;
            if (acc_o !== e.acc || acc_we_o !== e.we || flag_byte_o !== e.fb) begin
               bad++;
               $display("FAIL %s: op=%0d a=%h b=%h got acc=%h we=%b fl=%h exp acc=%h we=%b fl=%h",
                        e.req, op_i, acc_i, opnd_i, acc_o, acc_we_o, flag_byte_o,
                        e.acc, e.we, e.fb);
            end
            // R7: single flag outputs mirror the packed byte
            total++;
            if ({zf_o, nf_o, hf_o, cf_o} !== e.fb[7:4]) begin
               bad++;
               $display("FAIL R7: bits=%b exp=%b", {zf_o, nf_o, hf_o, cf_o}, e.fb[7:4]);
            end
         end
      end
   end

   initial begin
      logic [31:0] s;
      s = 32'h1234_5678;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // first vector: reserved code with clean flags (R8)
      drive(8'h5A, 8'hA5, 3'd7, 8'h00);
      // R1: zero result, nonzero result
      drive(8'hF0, 8'h0F, 3'd0, 8'h00);
      drive(8'h3C, 8'h2E, 3'd0, 8'hF0);
      // R2: OR, XOR to zero, OR of zeros
      drive(8'h12, 8'h40, 3'd1, 8'hF0);
      drive(8'h77, 8'h77, 3'd2, 8'h00);
      drive(8'h00, 8'h00, 3'd1, 8'h30);
      // R3: equal operands
      drive(8'h42, 8'h42, 3'd3, 8'h00);
      // R4: borrow, no borrow
      drive(8'h10, 8'h80, 3'd3, 8'h00);
      drive(8'h90, 8'h10, 3'd3, 8'hF0);
      // R5: half borrow only, full borrow without half
      drive(8'h20, 8'h01, 3'd3, 8'h00);
      drive(8'h0F, 8'h10, 3'd3, 8'h00);
      drive(8'h00, 8'hFF, 3'd3, 8'h00);
      // R6: flags in both polarities
      drive(8'hA5, 8'h00, 3'd4, 8'h90);
      drive(8'hFF, 8'h33, 3'd4, 8'h60);
      // R8: remaining reserved codes with nonzero low nibble in flag byte
      drive(8'h81, 8'h7E, 3'd5, 8'hF5);
      drive(8'h00, 8'hFF, 3'd6, 8'h3A);
      drive(8'hC3, 8'h3C, 3'd7, 8'hAF);
      // sweep over every code with pseudo-random data
      for (int k = 0; k < 400; k++) begin
         s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
         drive(s[7:0], (k % 9 == 0) ? s[7:0] : s[15:8], s[18:16], s[31:24]);
      end
      repeat (3) @(posedge clk);
      drv_done = 1'b1;
   end

   initial begin
      fork
         wait (drv_done);
         begin
            repeat (20000) @(posedge clk);
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, exp done got hung");
         end
      join_any
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule